// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core. Each request line is given one of three programmable priority tiers (low, medium, high) or switched off. A separate non-maskable input ranks above every programmable tier. The controller keeps one in-service flag per tier. A request is offered to the core only when its tier is enabled and ranks above every tier currently in service. This lets medium requests nest over low service routines, and high requests nest over both.

The core sees a valid flag and a word vector address. The vector for a line is a base address plus a fixed step per line index. The non-maskable request has its own vector. A relocation input adds a boot-area base to every vector. When the core acknowledges the offered request, the winning tier becomes in-service on the next clock edge. A return pulse retires only the most important tier that is in service. Inside the low tier, the winner is either the lowest line index or a rotating order. In the rotating order, the last low line acknowledged becomes the least favoured.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset no tier is in service (`active_o` = 0), and with no request pending `irq_valid` is low.
- R2: The two bits `irq_level[2i+1:2i]` give line i its tier: 0 = off, 1 = low, 2 = medium, 3 = high. A line set to off, or a line whose tier is disabled in `level_en` (bit 0 low, bit 1 medium, bit 2 high), is never offered.
- R3: Among offerable requests the highest tier wins. Within the medium tier, the high tier, and the low tier in fixed mode (`low_rr_en` = 0), the lowest line index wins.
- R4: A medium request is offered while only the low tier is in service. A low request is not offered while the low tier is in service.
- R5: A high request is offered while the low and medium tiers are in service. No request of the high tier or below is offered while the high tier is in service.
- R6: With `low_rr_en` = 1, the low-tier search starts at the line after the last acknowledged low line and wraps around. After reset that last line is NUM_SRC-1, so the search starts at line 0.
- R7: `nmi_req` is offered whenever the non-maskable flag (`active_o[3]`) is clear, whatever `level_en` holds. Its vector is word address 0x002.
- R8: Line i has vector LINE_BASE + LINE_STEP*i. The defaults are 0x004 and 2.
- R9: With `vec_reloc` = 1, BOOT_BASE (default 0x800) is added to every vector, including the non-maskable one.
- R10: `irq_ack` while `irq_valid` is high sets the winning tier's flag on the next edge. `active_o` bit 0 is low, bit 1 medium, bit 2 high and bit 3 non-maskable. An `irq_ack` while `irq_valid` is low changes nothing.
- R11: `irq_reti` clears only the most important set bit of `active_o` on the next edge. With no bit set it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Request lines, level sensitive |
| irq_level | input | 2*NUM_SRC | Tier code per line |
| level_en | input | 3 | Tier enables: low, medium, high |
| low_rr_en | input | 1 | Rotating order inside the low tier |
| vec_reloc | input | 1 | Add BOOT_BASE to vectors |
| nmi_req | input | 1 | Non-maskable request |
| irq_ack | input | 1 | Core takes the offered request |
| irq_reti | input | 1 | Return from the current routine |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | VEC_W | Word vector of the offered request |
| active_o | output | 4 | In-service flags: low, medium, high, non-maskable |

## Verification
The assertions assume that the core pulses `irq_reti` only at the end of a routine it entered. They also assume that `irq_ack` and `irq_reti` do not arrive in the same cycle, because the return check counts flags and expects the ack not to refill the cleared bit. The stimulus drives inputs in the falling half of the clock and never raises both pulses together. It issues returns only against a reference model of the in-service flags, so that a return with nothing in service is also covered as the deliberate no-op case.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {TIER_OFF = 2'd0, TIER_LOW = 2'd1, TIER_MED = 2'd2, TIER_HIGH = 2'd3} tier_e;

  // word vector of a request line
  function automatic int unsigned line_vec(int unsigned base, int unsigned step, int unsigned idx);
    return base + step * idx;
  endfunction

  // optional shift into the boot area
  function automatic int unsigned place_vec(int unsigned v, logic reloc, int unsigned boot);
    return reloc ? v + boot : v;
  endfunction

  // most important in-service tier, 0 when idle, 4 for non-maskable
  function automatic logic [2:0] top_of(logic [3:0] act);
    logic [2:0] t;
    t = 3'd0;
    for (int b = 0; b < 4; b++) if (act[b]) t = 3'(b + 1);
    return t;
  endfunction
endpackage

// File: rtl/nic_fixed_pick.sv
module nic_fixed_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nic_rr_pick.sv
module nic_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  mask,
  input  logic          rr_en,
  input  logic          take,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= idx;
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = rr_en ? (int'(last_q) + k) % N : k - 1;
      if (!hit && mask[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/nic_active_trk.sv
module nic_active_trk
  import nic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_fire,
  input  logic [2:0] win_tier,
  input  logic       reti_fire,
  output logic [3:0] act,
  output logic [2:0] top_tier
);
  logic [3:0] act_q, act_d;

  assign top_tier = top_of(act_q);
  assign act      = act_q;

  always_comb begin
    act_d = act_q;
    for (int b = 0; b < 4; b++) begin
      if (reti_fire && top_tier == 3'(b + 1)) act_d[b] = 1'b0;
      if (ack_fire && win_tier == 3'(b + 1))  act_d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end
endmodule

// File: rtl/nic_vec_gen.sv
module nic_vec_gen
  import nic_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int IW        = 3,
  parameter int LINE_BASE = 4,
  parameter int LINE_STEP = 2,
  parameter int NMI_VEC   = 2,
  parameter int BOOT_BASE = 'h800
) (
  input  logic [2:0]       win_tier,
  input  logic [IW-1:0]    win_idx,
  input  logic             reloc,
  output logic [VEC_W-1:0] vec
);
  int unsigned raw;
  always_comb begin
    raw = (win_tier == 3'd4) ? NMI_VEC : line_vec(LINE_BASE, LINE_STEP, int'(win_idx));
    vec = VEC_W'(place_vec(raw, reloc, BOOT_BASE));
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int VEC_W     = 16,
  parameter int LINE_BASE = 4,
  parameter int LINE_STEP = 2,
  parameter int NMI_VEC   = 2,
  parameter int BOOT_BASE = 'h800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic [2*NUM_SRC-1:0] irq_level,
  input  logic [2:0]           level_en,
  input  logic                 low_rr_en,
  input  logic                 vec_reloc,
  input  logic                 nmi_req,
  input  logic                 irq_ack,
  input  logic                 irq_reti,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vec,
  output logic [3:0]           active_o
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [2:0][NUM_SRC-1:0] tier_mask;
  logic [2:0]              tier_hit;
  logic [2:0][IW-1:0]      tier_idx;
  logic [2:0]              win_tier;
  logic [IW-1:0]           win_idx;
  logic [3:0]              act;
  logic [2:0]              top_tier;
  logic                    ack_fire, reti_fire, low_take;

  always_comb begin
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < NUM_SRC; i++)
        tier_mask[t][i] = irq_req[i] && (irq_level[2*i +: 2] == 2'(t + 1));
  end

  assign low_take = ack_fire && (win_tier == 3'd1);

  nic_rr_pick #(.N(NUM_SRC), .IW(IW)) u_low (
    .clk(clk), .rst_n(rst_n), .mask(tier_mask[0]), .rr_en(low_rr_en),
    .take(low_take), .hit(tier_hit[0]), .idx(tier_idx[0])
  );

  for (genvar g = 1; g < 3; g++) begin : g_fixed
    nic_fixed_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
      .mask(tier_mask[g]), .hit(tier_hit[g]), .idx(tier_idx[g])
    );
  end

  always_comb begin
    win_tier = 3'd0;
    win_idx  = '0;
    if (nmi_req && !act[3]) begin
      win_tier = 3'd4;
    end else begin
      for (int t = 2; t >= 0; t--) begin
        if (win_tier == 3'd0 && level_en[t] && tier_hit[t] && 3'(t + 1) > top_tier) begin
          win_tier = 3'(t + 1);
          win_idx  = tier_idx[t];
        end
      end
    end
  end

  assign irq_valid = (win_tier != 3'd0);
  assign ack_fire  = irq_ack && irq_valid;
  assign reti_fire = irq_reti && (|act);

  nic_active_trk u_trk (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .win_tier(win_tier),
    .reti_fire(reti_fire), .act(act), .top_tier(top_tier)
  );

  nic_vec_gen #(
    .VEC_W(VEC_W), .IW(IW), .LINE_BASE(LINE_BASE), .LINE_STEP(LINE_STEP),
    .NMI_VEC(NMI_VEC), .BOOT_BASE(BOOT_BASE)
  ) u_vec (
    .win_tier(win_tier), .win_idx(win_idx), .reloc(vec_reloc), .vec(irq_vec)
  );

  assign active_o = act;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               nmi_req,
  input logic               irq_valid,
  input logic               ack_fire,
  input logic               reti_fire,
  input logic [2:0]         win_tier,
  input logic [2:0]         top_tier,
  input logic [3:0]         act
);
  // R7
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req && !act[3] |-> irq_valid && win_tier == 3'd4);

  // R4
  nest_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && win_tier != 3'd4 |-> win_tier > top_tier);

  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_req) && !nmi_req |-> !irq_valid);

  // R10
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> top_tier == $past(win_tier));

  // R11
  reti_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_fire && !ack_fire |=> $countones(act) == $countones($past(act)) - 1 && top_tier < $past(top_tier));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire && !reti_fire |=> $stable(act));
endmodule

bind nested_irq_ctrl nic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
  .irq_valid(irq_valid), .ack_fire(ack_fire), .reti_fire(reti_fire),
  .win_tier(win_tier), .top_tier(top_tier), .act(act)
);

// File: tb/nested_irq_ctrl_bench.sv
`timescale 1ns/100ps
module nested_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_req = '0;
  logic [15:0] irq_level = '0;
  logic [2:0]  level_en = '0;
  logic        low_rr_en = 1'b0, vec_reloc = 1'b0, nmi_req = 1'b0;
  logic        irq_ack = 1'b0, irq_reti = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vec;
  logic [3:0]  active_o;

  always #2 clk = ~clk;

  nested_irq_ctrl u_nested_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
    .level_en(level_en), .low_rr_en(low_rr_en), .vec_reloc(vec_reloc),
    .nmi_req(nmi_req), .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .active_o(active_o)
  );

  typedef struct {
    logic        valid;
    logic [15:0] vec;
    logic [3:0]  act;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 0;
  logic [3:0] m_act = '0;
  int   m_last = 7;

  function automatic logic [15:0] lv(int line, int tier);
    return 16'(tier) << (2 * line);
  endfunction

  // driver: apply one cycle of stimulus and queue what the ports must show
  task automatic step(input logic [7:0] rq, input logic [15:0] cfg, input logic [2:0] en,
                      input logic rr, input logic rl, input logic nm,
                      input logic ak, input logic rt, input string tag);
    exp_t e;
    int   top, wt, wi;
    @(negedge clk);
    irq_req = rq; irq_level = cfg; level_en = en; low_rr_en = rr;
    vec_reloc = rl; nmi_req = nm; irq_ack = ak; irq_reti = rt;
    #0.5;
    top = 0;
    for (int b = 0; b < 4; b++) if (m_act[b]) top = b + 1;
    wt = 0; wi = 0;
    if (nm && !m_act[3]) wt = 4;
    else
      for (int t = 3; t >= 1; t--)
        if (wt == 0 && en[t-1] && t > top)
          for (int k = 0; k < 8; k++) begin
            int i;
            i = (t == 1 && rr) ? (m_last + 1 + k) % 8 : k;
            if (wt == 0 && rq[i] && int'(cfg[2*i +: 2]) == t) begin wt = t; wi = i; end
          end
    e.valid = (wt != 0);
    e.vec   = (wt == 4) ? 16'h0002 : 16'(4 + 2 * wi);
    if (rl) e.vec = e.vec + 16'h0800;
    e.act = m_act;
    e.tag = tag;
    q.push_back(e);
    if (rt && top > 0) m_act[top-1] = 1'b0;
    if (ak && wt != 0) begin
      m_act[wt-1] = 1'b1;
      if (wt == 1) m_last = wi;
    end
  endtask

  // monitor: compare ports against the queued expectation before the next edge
  initial forever begin
    exp_t e;
    @(negedge clk);
    #1.5;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (irq_valid !== e.valid || active_o !== e.act || (e.valid && irq_vec !== e.vec)) begin
        errors++;
        $display("FAIL %s: valid=%0b vec=%h act=%b, expected valid=%0b vec=%h act=%b",
                 e.tag, irq_valid, irq_vec, active_o, e.valid, e.vec, e.act);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] low3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(8'h00, 16'h0, 3'b111, 0, 0, 0, 0, 0, "R1 idle");
    low3 = lv(3, 1) | lv(5, 1);
    step(8'h28, low3, 3'b111, 0, 0, 0, 0, 0, "R3 R8 low line 3");
    step(8'h28, low3, 3'b111, 0, 0, 0, 1, 0, "R10 ack low");
    step(8'h20, low3, 3'b111, 0, 0, 0, 0, 0, "R4 low blocked");
    step(8'h60, low3 | lv(6, 2), 3'b111, 0, 0, 0, 1, 0, "R4 medium nests");
    step(8'hA4, lv(2, 2) | lv(7, 3) | lv(5, 1), 3'b111, 0, 0, 0, 1, 0, "R5 high nests");
    step(8'h84, lv(2, 2) | lv(7, 3), 3'b111, 0, 0, 0, 0, 0, "R5 high blocked");
    step(8'h00, 16'h0, 3'b000, 0, 0, 1, 1, 0, "R7 nmi");
    step(8'h00, 16'h0, 3'b111, 0, 0, 1, 0, 0, "R7 nmi blocked");
    step(8'h00, 16'h0, 3'b111, 0, 0, 0, 1, 0, "R10 ack ignored");
    for (int r = 0; r < 5; r++)
      step(8'h00, 16'h0, 3'b111, 0, 0, 0, 0, 1, "R11 reti");
    step(8'h00, 16'h0, 3'b111, 0, 0, 0, 0, 0, "R11 none left");
    step(8'h00, 16'h0, 3'b111, 0, 1, 1, 0, 0, "R9 nmi relocated");
    step(8'h02, lv(1, 1), 3'b111, 0, 1, 0, 0, 0, "R9 line relocated");
    step(8'h02, 16'h0, 3'b111, 0, 0, 0, 0, 0, "R2 tier off");
    step(8'h02, lv(1, 1), 3'b110, 0, 0, 0, 0, 0, "R2 tier disabled");
    step(8'h44, lv(2, 2) | lv(6, 2), 3'b111, 0, 0, 0, 0, 0, "R3 medium lowest");
    step(8'h52, lv(1, 1) | lv(4, 1) | lv(6, 1), 3'b111, 0, 0, 0, 1, 0, "R3 fixed low");
    step(8'h00, 16'h0, 3'b111, 0, 0, 0, 0, 1, "R11 reti low");
    for (int r = 0; r < 3; r++) begin
      step(8'h52, lv(1, 1) | lv(4, 1) | lv(6, 1), 3'b111, 1, 0, 0, 1, 0, "R6 rotate");
      step(8'h00, 16'h0, 3'b111, 1, 0, 0, 0, 1, "R11 reti rotate");
    end
    step(8'h52, lv(1, 1) | lv(4, 1) | lv(6, 1), 3'b111, 0, 0, 0, 0, 0, "R3 fixed again");
    step(8'h00, 16'h0, 3'b111, 0, 0, 0, 0, 0, "R1 settle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule